// File: doc/BRIEF.md
# Multiport Shared Memory Conflict Resolver

This block is a small shared memory used by several processor ports that all run on one clock. In each cycle every port can issue one access, a read or a write. When two or more ports use the same address in the same cycle, the block resolves the collision according to an access discipline chosen on a mode input. It commits at most one write to each address, returns registered read data to every reading port and raises a sticky error flag for any access that the chosen discipline does not allow. The flag also records the address that caused the error.

The disciplines are as follows. In the fully exclusive discipline, no two ports may share an address in the same cycle, whether they read or write. In the concurrent-read discipline, shared reads are allowed but shared writes are not. The three concurrent-write disciplines allow shared writes and differ in which value they commit: a common value, a rotating arbitrary choice, or the lowest port index. Reads always see the memory contents from before the clock edge, and writes take effect at that edge.

Top module: `mp_shared_mem`

## Requirements
- R1: After reset, every port's read data is 0, `err_flag` is 0, `err_addr` is 0, every memory word reads as 0 and the arbitration pointer is 0.
- R2: A write issued in cycle k is visible to a read issued in cycle k+1 or later. A read issued in cycle k drives that port's `rd_data` slice from the first clock edge after cycle k. The slice holds its value in any cycle in which the port issues no read.
- R3: A read and a write to the same address in the same cycle return the old word to the reader, and the write then commits normally.
- R4: The mode encoding is 0 = exclusive read and exclusive write, 1 = concurrent read with exclusive write, 2 = concurrent write with a common value, 3 = concurrent write with an arbitrary winner, 4 = concurrent write with a priority winner. Codes 5 to 7 behave exactly like code 0.
- R5: In the fully exclusive mode, two or more ports reading one address in a cycle is a violation. In every mode, each reading port still receives the stored word. In modes 1 to 4, shared reads raise no error.
- R6: In modes 0 and 1, two or more ports writing one address in a cycle is a violation, and no write is committed to that address. In the same cycle, a write by a single port to a different address still commits.
- R7: In mode 2, colliding writers that all present the same value commit that value with no error. If any of their values differ, the collision is a violation and nothing is committed to that address.
- R8: In mode 3, the winner among the colliding writers is the first of them in ascending cyclic port order, starting at the pointer. The pointer increments by one, modulo the port count, after each mode-3 cycle that contains at least one write collision. Other cycles leave the pointer unchanged.
- R9: In mode 4, the colliding writer with the lowest port index commits, and no error is raised.
- R10: `err_flag` rises at the clock edge that ends a cycle containing a violation. It stays high until a cycle in which `err_clr` is 1 and no violation occurs. A violation in the same cycle as `err_clr` keeps the flag set.
- R11: `err_addr` captures the address of the lowest-indexed port involved in a violation. The capture happens when the flag is clear or `err_clr` is 1. While the flag stays set without a clear, `err_addr` does not change.
- R12: Writes to different addresses in the same cycle all commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Access discipline select |
| req_valid | input | NPORT | Access request, one bit per port |
| req_we | input | NPORT | 1 = write, 0 = read, one bit per port |
| req_addr | input | NPORT*AW | Word address, port p at bits [p*AW +: AW] |
| req_wdata | input | NPORT*DW | Write data, port p at bits [p*DW +: DW] |
| err_clr | input | 1 | Clear request for the sticky error flag |
| rd_data | output | NPORT*DW | Registered read data, port p at bits [p*DW +: DW] |
| err_flag | output | 1 | Sticky violation flag |
| err_addr | output | AW | Address that caused the captured violation |

## Verification
The hardest state to reach is the arbitration pointer, which is never visible at the ports. It can only be inferred from which writer wins a mode-3 collision. The stimulus starts from the known pointer value after reset and drives a chain of colliding write pairs. Each pair is chosen so that the expected winner changes as the pointer moves past the colliding ports. The winning value is read back after every step. A single non-colliding mode-3 write is placed between two collisions to show that it does not move the pointer.

// File: rtl/mp_shared_mem.sv
module mp_shared_mem #(
  parameter int NPORT = 4,
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2:0]                mode,
  input  logic [NPORT-1:0]          req_valid,
  input  logic [NPORT-1:0]          req_we,
  input  logic [NPORT*((DEPTH>1)?$clog2(DEPTH):1)-1:0] req_addr,
  input  logic [NPORT*DW-1:0]       req_wdata,
  input  logic                      err_clr,
  output logic [NPORT*DW-1:0]       rd_data,
  output logic                      err_flag,
  output logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] err_addr
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PW = (NPORT > 1) ? $clog2(NPORT) : 1;
  localparam logic [2:0] M_EXCL = 3'd0, M_CREW = 3'd1, M_COMMON = 3'd2,
                         M_ARB = 3'd3, M_PRIO = 3'd4;

  function automatic int rdist(int q, int base);
    return (q >= base) ? q - base : q + NPORT - base;
  endfunction

  logic [DW-1:0]    mem [DEPTH];
  logic [DW-1:0]    rd_q [NPORT];
  logic [AW-1:0]    ad [NPORT];
  logic [DW-1:0]    wd [NPORT];
  logic [NPORT-1:0] wgrp [NPORT];
  logic [NPORT-1:0] is_rd, is_wr, rmulti, wmulti, wsame, wfirst, awin, win, viol;
  logic [AW-1:0]    vaddr;
  logic [PW-1:0]    ptr;

  wire rd_excl  = (mode == M_EXCL) || (mode > M_PRIO);
  wire wr_excl  = rd_excl || (mode == M_CREW);
  wire any_viol = |viol;
  wire arb_step = (mode == M_ARB) && (|wmulti);

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      ad[p]    = req_addr[p*AW +: AW];
      wd[p]    = req_wdata[p*DW +: DW];
      is_rd[p] = req_valid[p] && !req_we[p];
      is_wr[p] = req_valid[p] && req_we[p];
    end
    vaddr = '0;
    for (int p = 0; p < NPORT; p++) begin
      rmulti[p] = 1'b0;
      wmulti[p] = 1'b0;
      wsame[p]  = 1'b1;
      wfirst[p] = 1'b1;
      awin[p]   = 1'b1;
      wgrp[p]   = '0;
      for (int q = 0; q < NPORT; q++) begin
        wgrp[p][q] = is_wr[p] && is_wr[q] && (ad[q] == ad[p]);
        if (q != p) begin
          if (is_rd[p] && is_rd[q] && (ad[q] == ad[p])) rmulti[p] = 1'b1;
          if (wgrp[p][q]) begin
            wmulti[p] = 1'b1;
            if (wd[q] != wd[p]) wsame[p] = 1'b0;
            if (q < p) wfirst[p] = 1'b0;
            if (rdist(q, int'(ptr)) < rdist(p, int'(ptr))) awin[p] = 1'b0;
          end
        end
      end
      win[p] = is_wr[p] && (!wmulti[p]
               || ((mode == M_COMMON) && wsame[p] && wfirst[p])
               || ((mode == M_ARB) && awin[p])
               || ((mode == M_PRIO) && wfirst[p]));
      viol[p] = (rmulti[p] && rd_excl) || (wmulti[p] && wr_excl)
             || (wmulti[p] && (mode == M_COMMON) && !wsame[p]);
    end
    for (int p = NPORT - 1; p >= 0; p--)
      if (viol[p]) vaddr = ad[p];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      for (int p = 0; p < NPORT; p++) rd_q[p] <= '0;
      ptr      <= '0;
      err_flag <= 1'b0;
      err_addr <= '0;
    end else begin
      for (int p = 0; p < NPORT; p++) begin
        if (win[p])   mem[ad[p]] <= wd[p];
        if (is_rd[p]) rd_q[p]    <= mem[ad[p]];
      end
      if (arb_step)
        ptr <= (int'(ptr) == NPORT - 1) ? '0 : ptr + 1'b1;
      if (any_viol) begin
        err_flag <= 1'b1;
        if (!err_flag || err_clr) err_addr <= vaddr;
      end else if (err_clr) begin
        err_flag <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    assign rd_data[g*DW +: DW] = rd_q[g];

    a_r5_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(win & wgrp[g]));

    a_r6_excl_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_excl && is_wr[g] && ((wgrp[g] & ~(NPORT'(1) << g)) != '0)) |-> !win[g]);

    a_r9_prio_lowest: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == M_PRIO) && win[g]) |-> ((wgrp[g] & NPORT'((1 << g) - 1)) == '0));
  end

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag);

  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !any_viol) |=> !err_flag);

  a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> $stable(err_addr));

  a_r8_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr) < NPORT);
endmodule

// File: tb/mp_shared_mem_tb.sv
module mp_shared_mem_tb;
  localparam int NPORT = 4, DEPTH = 16, DW = 8, AW = 4;

  logic clk = 0, rst_n = 0, err_clr = 0;
  logic [2:0] mode = 0;
  logic [NPORT-1:0] req_valid = 0, req_we = 0;
  logic [NPORT*AW-1:0] req_addr = 0;
  logic [NPORT*DW-1:0] req_wdata = 0;
  logic [NPORT*DW-1:0] rd_data;
  logic err_flag;
  logic [AW-1:0] err_addr;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  mp_shared_mem #(.NPORT(NPORT), .DEPTH(DEPTH), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .err_clr(err_clr),
    .rd_data(rd_data), .err_flag(err_flag), .err_addr(err_addr));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(int p, int a);
    req_valid[p] = 1; req_we[p] = 0; req_addr[p*AW +: AW] = AW'(a);
  endtask

  task automatic wr(int p, int a, int d);
    req_valid[p] = 1; req_we[p] = 1; req_addr[p*AW +: AW] = AW'(a);
    req_wdata[p*DW +: DW] = DW'(d);
  endtask

  task automatic step();
    @(posedge clk); #1;
    req_valid = 0; req_we = 0; err_clr = 0;
  endtask

  function automatic int rdp(int p);
    return int'(rd_data[p*DW +: DW]);
  endfunction

  task automatic peek(string req, int a, int exp);
    rd(0, a); step(); chk(req, rdp(0), exp);
  endtask

  task automatic clear_err();
    err_clr = 1; step();
  endtask

  task automatic t_reset();
    for (int p = 0; p < NPORT; p++) chk("R1 rd_data", rdp(p), 0);
    chk("R1 err_flag", err_flag, 0);
    chk("R1 err_addr", err_addr, 0);
    peek("R1 mem zero", 5, 0);
  endtask

  task automatic t_basic();
    mode = 1;
    wr(1, 3, 'h5A); step();
    rd(2, 3); step(); chk("R2 read after write", rdp(2), 'h5A);
    step(); chk("R2 hold", rdp(2), 'h5A);
    wr(0, 1, 'h10); wr(1, 2, 'h20); wr(2, 12, 'h30); wr(3, 14, 'h40); step();
    rd(0, 1); rd(1, 2); rd(2, 12); rd(3, 14); step();
    chk("R12 p0", rdp(0), 'h10); chk("R12 p1", rdp(1), 'h20);
    chk("R12 p2", rdp(2), 'h30); chk("R12 p3", rdp(3), 'h40);
    chk("R12 no err", err_flag, 0);
  endtask

  task automatic t_rbw();
    wr(0, 3, 'h11); rd(1, 3); step();
    chk("R3 old data", rdp(1), 'h5A);
    peek("R3 new data", 3, 'h11);
  endtask

  task automatic t_reads();
    mode = 0; rd(0, 3); rd(2, 3); step();
    chk("R5 excl rd p0", rdp(0), 'h11); chk("R5 excl rd p2", rdp(2), 'h11);
    chk("R5 excl flag", err_flag, 1); chk("R5 excl addr", err_addr, 3);
    clear_err(); chk("R10 cleared", err_flag, 0);
    mode = 2; for (int p = 0; p < NPORT; p++) rd(p, 1); step();
    for (int p = 0; p < NPORT; p++) chk("R5 concurrent data", rdp(p), 'h10);
    chk("R5 concurrent no flag", err_flag, 0);
    mode = 7; rd(1, 2); rd(3, 2); step();
    chk("R4 code7 flag", err_flag, 1); chk("R4 code7 addr", err_addr, 2);
    clear_err();
  endtask

  task automatic t_excl_write();
    mode = 1; wr(1, 7, 'h22); wr(3, 7, 'h33); wr(0, 8, 'h44); step();
    chk("R6 flag", err_flag, 1); chk("R6 addr", err_addr, 7);
    clear_err();
    peek("R6 no commit", 7, 0);
    peek("R6 other commits", 8, 'h44);
  endtask

  task automatic t_common();
    mode = 2; wr(0, 9, 'h66); wr(1, 9, 'h66); wr(2, 9, 'h66); step();
    chk("R7 equal no flag", err_flag, 0);
    peek("R7 equal commit", 9, 'h66);
    wr(1, 9, 'h70); wr(2, 9, 'h71); step();
    chk("R7 mismatch flag", err_flag, 1); chk("R7 mismatch addr", err_addr, 9);
    clear_err();
    peek("R7 mismatch no commit", 9, 'h66);
  endtask

  task automatic t_prio();
    mode = 4; wr(3, 10, 'h31); wr(1, 10, 'h11); wr(2, 10, 'h21); step();
    chk("R9 no flag", err_flag, 0);
    peek("R9 lowest wins", 10, 'h11);
    wr(3, 10, 'h32); wr(2, 10, 'h22); step();
    peek("R9 lowest wins 2", 10, 'h22);
  endtask

  task automatic t_arb();
    mode = 3;
    wr(1, 11, 'hA1); wr(2, 11, 'hA2); step(); peek("R8 ptr0", 11, 'hA1);
    wr(0, 11, 'hB0); wr(1, 11, 'hB1); step(); peek("R8 ptr1", 11, 'hB1);
    wr(0, 11, 'hC0); wr(1, 11, 'hC1); step(); peek("R8 ptr2 wrap", 11, 'hC0);
    wr(3, 11, 'hD3); wr(0, 11, 'hD0); step(); peek("R8 ptr3", 11, 'hD3);
    wr(2, 12, 'h55); step();
    wr(0, 11, 'hE0); wr(3, 11, 'hE3); step(); peek("R8 ptr back 0", 11, 'hE0);
    chk("R8 no flag", err_flag, 0);
  endtask

  task automatic t_sticky();
    mode = 0; rd(2, 4); rd(3, 4); step();
    chk("R10 set", err_flag, 1); chk("R11 addr", err_addr, 4);
    wr(0, 6, 1); wr(1, 6, 2); step();
    chk("R10 held", err_flag, 1); chk("R11 addr held", err_addr, 4);
    err_clr = 1; rd(1, 5); rd(2, 5); step();
    chk("R10 clr with viol", err_flag, 1); chk("R11 recapture", err_addr, 5);
    clear_err(); chk("R10 clr", err_flag, 0);
    rd(2, 14); rd(3, 14); wr(0, 15, 1); wr(1, 15, 2); step();
    chk("R11 lowest port", err_addr, 15);
    clear_err();
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_basic();
    t_rbw();
    t_reads();
    t_excl_write();
    t_common();
    t_prio();
    t_arb();
    t_sticky();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule